// File: doc/BRIEF.md
# Host-Commanded Power Mode Controller

This block is the power state machine of a low-power accelerator subsystem. A host processor writes mode commands into it through a register front end. The front end, such as a serial slave, is not part of this block. The controller drives the enables that decide which parts of the chip are clocked and powered. Two clock enables cover the main domain and the accelerator. The island enable switches the accelerator's power supply, and the isolation enable clamps that island's outputs while it is unpowered. The controller also drives an active-high external shutdown pin and an enable for the always-on low-frequency domain. That always-on domain keeps running while the main domain is gated, and it delivers a wake event that brings the subsystem back to full operation.

There are four steady modes. In ACTIVE, everything is on. In IDLE, the accelerator clock is gated. In SLEEP, the clocks are off, the island is off and isolation is on. In HIBERNATE, all clocks are halted, the always-on domain is included and the shutdown pin is raised, but configuration state is kept. A move that crosses a power boundary passes through four transitional states. Power-down goes through PD_GATE, where the clocks are off for a fixed window, and then PD_ISO, where isolation is raised. Power-up goes through PU_PWR, where the island is on and the controller waits for power-good, and then PU_ISO, where isolation is released. The wake and power-good inputs are synchronized on entry.

Named transitions:
- ACTIVE<->IDLE and SLEEP<->HIBERNATE switch directly.
- ACTIVE/IDLE -> PD_GATE -> PD_ISO -> SLEEP/HIBERNATE.
- SLEEP/HIBERNATE -> PU_PWR -> PU_ISO -> ACTIVE/IDLE.
- A wake event takes IDLE -> ACTIVE and SLEEP -> PU_PWR (target ACTIVE).

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller is in ACTIVE. Mode reads 2'b00, busy is 0, the error flag is 0, and the enables show the ACTIVE settings.
- R2: Mode codes are 00 ACTIVE, 01 IDLE, 10 SLEEP and 11 HIBERNATE. The outputs in the order {main clock, accel clock, island, isolation, shutdown, always-on} are 111001 for ACTIVE, 101001 for IDLE, 000101 for SLEEP and 000110 for HIBERNATE.
- R3: Every legal command is first registered. A direct move (ACTIVE<->IDLE or SLEEP<->HIBERNATE) shows its new settings and mode two cycles after the command cycle.
- R4: Power-down shows PD_GATE (001001, busy) for 4 cycles starting two cycles after the command. It then shows PD_ISO (001101) for one cycle, and only then the island-off steady mode.
- R5: Power-up shows PU_PWR (001101, shutdown low, busy) until the synchronized power-good input is high. It then shows PU_ISO (001001) for one cycle, then the target mode.
- R6: A wake pulse in IDLE gives ACTIVE three cycles later. A wake pulse in SLEEP starts power-up toward ACTIVE three cycles later.
- R7: A wake pulse in HIBERNATE has no effect. Only a host command leaves HIBERNATE.
- R8: A command that arrives during a transition is held and applied once the steady mode is reached. When several commands arrive, the newest legal one wins.
- R9: A command code with any bit above bit 1 set is illegal. It is ignored and raises a sticky error flag one cycle later. The flag is cleared by err_clr, and a new illegal code wins over a clear in the same cycle.
- R10: busy is high exactly in the transitional states. The mode output keeps the last steady mode until the next one is reached.
- R11: A command for the current mode changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | CODE_W | Requested mode code |
| err_clr | input | 1 | Clears the sticky error flag |
| wake | input | 1 | Wake event from the always-on domain |
| pgood | input | 1 | Island power-good indication |
| main_clk_en | output | 1 | Main domain clock enable |
| accel_clk_en | output | 1 | Accelerator clock enable |
| island_en | output | 1 | Accelerator power-island enable |
| iso_en | output | 1 | Island output isolation |
| shdn | output | 1 | External shutdown pin, active high |
| aon_en | output | 1 | Always-on low-frequency domain enable |
| busy | output | 1 | Transition in progress |
| mode | output | 2 | Current steady mode |
| err | output | 1 | Sticky illegal-command flag |

## Verification
The embedded properties check on every cycle that the power ordering is safe. No clock runs while the island is off or isolated. The island only drops after a cycle of isolation, and isolation only releases after power-good. They also check that HIBERNATE is never left without a command, and that an illegal code always raises the error flag. Only the bench scenarios can show the exact cycle counts of each sequence, the holding of a mid-transition command with the newest command winning, the wake latency from IDLE and SLEEP, and the error-clear behaviour.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'b00,
        MODE_IDLE   = 2'b01,
        MODE_SLEEP  = 2'b10,
        MODE_HIBER  = 2'b11
    } pm_mode_e;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_IDLE,
        ST_SLEEP,
        ST_HIBER,
        ST_PD_GATE,
        ST_PD_ISO,
        ST_PU_PWR,
        ST_PU_ISO
    } pm_state_e;

    typedef struct packed {
        logic main_clk;
        logic accel_clk;
        logic island;
        logic iso;
        logic shdn;
        logic aon;
    } pm_ctl_t;

    // steady state that holds a given mode
    function automatic pm_state_e steady_of(pm_mode_e m);
        pm_state_e s;
        unique case (m)
            MODE_ACTIVE: s = ST_ACTIVE;
            MODE_IDLE:   s = ST_IDLE;
            MODE_SLEEP:  s = ST_SLEEP;
            MODE_HIBER:  s = ST_HIBER;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_cmd.sv
module pmc_cmd
    import pmc_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              err_clr,
    input  logic              take,
    output logic              req_valid,
    output pm_mode_e          req_mode,
    output logic              err
);
    localparam int HI_W = CODE_W - 2;

    logic     legal;
    logic     pend_valid_q;
    pm_mode_e pend_mode_q;
    logic     err_q;

    assign legal = (cmd_code[CODE_W-1:2] == {HI_W{1'b0}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid_q <= 1'b0;
            pend_mode_q  <= MODE_ACTIVE;
            err_q        <= 1'b0;
        end else begin
            if (cmd_valid && legal) begin
                pend_valid_q <= 1'b1;
                pend_mode_q  <= pm_mode_e'(cmd_code[1:0]);
            end else if (take) begin
                pend_valid_q <= 1'b0;
            end
            if (cmd_valid && !legal) err_q <= 1'b1;
            else if (err_clr)        err_q <= 1'b0;
        end
    end

    assign req_valid = pend_valid_q;
    assign req_mode  = pend_mode_q;
    assign err       = err_q;

    // R9: an illegal code always raises the flag
    assert_illegal_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !legal) |=> err_q);

    // R9: an illegal code never creates a request
    assert_illegal_no_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !legal && !pend_valid_q) |=> !pend_valid_q);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int GATE_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  pm_mode_e req_mode,
    input  logic     wake_s,
    input  logic     pgood_s,
    output logic     take,
    output pm_ctl_t  ctl,
    output logic     busy,
    output pm_mode_e mode
);
    localparam int CNT_W = (GATE_CYC > 2) ? $clog2(GATE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GATE_CYC - 1);

    pm_state_e        st, st_n;
    pm_mode_e         tgt, tgt_n, mode_q, mode_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             steady, go;
    pm_mode_e         dest;

    assign steady = (st == ST_ACTIVE) || (st == ST_IDLE) ||
                    (st == ST_SLEEP)  || (st == ST_HIBER);

    // request selection: host command first, then wake
    always_comb begin
        go   = 1'b0;
        dest = mode_q;
        take = 1'b0;
        if (steady) begin
            if (req_valid) begin
                go   = 1'b1;
                dest = req_mode;
                take = 1'b1;
            end else if (wake_s && (st == ST_IDLE || st == ST_SLEEP)) begin
                go   = 1'b1;
                dest = MODE_ACTIVE;
            end
        end
    end

    // next state
    always_comb begin
        st_n   = st;
        tgt_n  = tgt;
        cnt_n  = cnt;
        mode_n = mode_q;
        unique case (st)
            ST_ACTIVE, ST_IDLE, ST_SLEEP, ST_HIBER: begin
                if (go && dest != mode_q) begin
                    tgt_n = dest;
                    cnt_n = '0;
                    if (mode_q[1] == dest[1]) begin
                        st_n   = steady_of(dest);
                        mode_n = dest;
                    end else if (dest[1]) begin
                        st_n = ST_PD_GATE;
                    end else begin
                        st_n = ST_PU_PWR;
                    end
                end
            end
            ST_PD_GATE: begin
                if (cnt == CNT_LAST) st_n = ST_PD_ISO;
                else                 cnt_n = cnt + 1'b1;
            end
            ST_PD_ISO: begin
                st_n   = steady_of(tgt);
                mode_n = tgt;
            end
            ST_PU_PWR: begin
                if (pgood_s) st_n = ST_PU_ISO;
            end
            ST_PU_ISO: begin
                st_n   = steady_of(tgt);
                mode_n = tgt;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_ACTIVE;
            tgt    <= MODE_ACTIVE;
            mode_q <= MODE_ACTIVE;
            cnt    <= '0;
        end else begin
            st     <= st_n;
            tgt    <= tgt_n;
            mode_q <= mode_n;
            cnt    <= cnt_n;
        end
    end

    // outputs per state
    always_comb begin
        busy = !steady;
        unique case (st)
            ST_ACTIVE:  ctl = '{main_clk:1'b1, accel_clk:1'b1, island:1'b1, iso:1'b0, shdn:1'b0, aon:1'b1};
            ST_IDLE:    ctl = '{main_clk:1'b1, accel_clk:1'b0, island:1'b1, iso:1'b0, shdn:1'b0, aon:1'b1};
            ST_SLEEP:   ctl = '{main_clk:1'b0, accel_clk:1'b0, island:1'b0, iso:1'b1, shdn:1'b0, aon:1'b1};
            ST_HIBER:   ctl = '{main_clk:1'b0, accel_clk:1'b0, island:1'b0, iso:1'b1, shdn:1'b1, aon:1'b0};
            ST_PD_GATE: ctl = '{main_clk:1'b0, accel_clk:1'b0, island:1'b1, iso:1'b0, shdn:1'b0, aon:1'b1};
            ST_PD_ISO:  ctl = '{main_clk:1'b0, accel_clk:1'b0, island:1'b1, iso:1'b1, shdn:1'b0, aon:1'b1};
            ST_PU_PWR:  ctl = '{main_clk:1'b0, accel_clk:1'b0, island:1'b1, iso:1'b1, shdn:1'b0, aon:1'b1};
            ST_PU_ISO:  ctl = '{main_clk:1'b0, accel_clk:1'b0, island:1'b1, iso:1'b0, shdn:1'b0, aon:1'b1};
        endcase
    end

    assign mode = mode_q;

    // R2: a running clock needs a powered, unclamped island
    assert_clk_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.main_clk || ctl.accel_clk) |-> (ctl.island && !ctl.iso));

    // R4: the island only drops after a cycle of isolation
    assert_iso_before_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.island) |-> $past(ctl.iso));

    // R5: isolation is released only after power-good was seen
    assert_pgood_before_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PU_ISO) |-> $past(pgood_s));

    // R7: hibernate is left only by a host request
    assert_hiber_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIBER && !req_valid) |=> (st == ST_HIBER));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CODE_W      = 3,
    parameter int GATE_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              err_clr,
    input  logic              wake,
    input  logic              pgood,
    output logic              main_clk_en,
    output logic              accel_clk_en,
    output logic              island_en,
    output logic              iso_en,
    output logic              shdn,
    output logic              aon_en,
    output logic              busy,
    output logic [1:0]        mode,
    output logic              err
);
    logic     wake_s, pgood_s, req_valid, take;
    pm_mode_e req_mode, mode_e;
    pm_ctl_t  ctl;

    pmc_sync #(.STAGES(SYNC_STAGES)) u_wake_sync (
        .clk(clk), .rst_n(rst_n), .d(wake), .q(wake_s));

    pmc_sync #(.STAGES(SYNC_STAGES)) u_pgood_sync (
        .clk(clk), .rst_n(rst_n), .d(pgood), .q(pgood_s));

    pmc_cmd #(.CODE_W(CODE_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .err_clr(err_clr), .take(take), .req_valid(req_valid),
        .req_mode(req_mode), .err(err));

    pmc_fsm #(.GATE_CYC(GATE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .wake_s(wake_s), .pgood_s(pgood_s), .take(take), .ctl(ctl),
        .busy(busy), .mode(mode_e));

    assign main_clk_en  = ctl.main_clk;
    assign accel_clk_en = ctl.accel_clk;
    assign island_en    = ctl.island;
    assign iso_en       = ctl.iso;
    assign shdn         = ctl.shdn;
    assign aon_en       = ctl.aon;
    assign mode         = mode_e;
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [5:0] C_ACT = 6'b111001;
    localparam logic [5:0] C_IDL = 6'b101001;
    localparam logic [5:0] C_SLP = 6'b000101;
    localparam logic [5:0] C_HIB = 6'b000110;
    localparam logic [5:0] C_PDG = 6'b001001;
    localparam logic [5:0] C_PDI = 6'b001101;
    localparam logic [5:0] C_PUL = 6'b001101;
    localparam logic [5:0] C_PUO = 6'b001001;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, cmd_valid, err_clr, wake, pgood;
    logic [2:0] cmd_code;
    logic       main_clk_en, accel_clk_en, island_en, iso_en, shdn, aon_en, busy, err;
    logic [1:0] mode;

    pwr_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .err_clr(err_clr), .wake(wake), .pgood(pgood),
        .main_clk_en(main_clk_en), .accel_clk_en(accel_clk_en),
        .island_en(island_en), .iso_en(iso_en), .shdn(shdn), .aon_en(aon_en),
        .busy(busy), .mode(mode), .err(err));

    typedef struct {
        int         at;
        logic [9:0] v;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    wire [9:0] obs = {main_clk_en, accel_clk_en, island_en, iso_en, shdn, aon_en,
                      busy, mode, err};

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items when their cycle comes up
    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].at <= cyc) begin
            e = q.pop_front();
            n_chk++;
            if (e.at != cyc || obs !== e.v) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b (cycle %0d)", e.tag, obs, e.v, cyc);
            end
        end
    end

    // driver side: queue an expectation dly cycles from now
    task automatic expect_at(int dly, logic [5:0] c, logic b, logic [1:0] m,
                             logic er, string tag);
        exp_t e;
        int   i;
        e.at  = cyc + dly;
        e.v   = {c, b, m, er};
        e.tag = tag;
        i = q.size();
        while (i > 0 && q[i-1].at > e.at) i--;
        q.insert(i, e);
    endtask

    task automatic send(logic [2:0] code);
        cmd_code  = code;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 3'd0;
        err_clr = 1'b0; wake = 1'b0; pgood = 1'b1;
        step(3);
        rst_n = 1'b1;

        // R1 reset state
        expect_at(1, C_ACT, 1'b0, 2'b00, 1'b0, "R1 reset state");
        step(2);

        // R11 same-mode command
        expect_at(2, C_ACT, 1'b0, 2'b00, 1'b0, "R11 same mode");
        expect_at(3, C_ACT, 1'b0, 2'b00, 1'b0, "R11 same mode later");
        send(3'd0);
        step(4);

        // R3 active to idle
        expect_at(1, C_ACT, 1'b0, 2'b00, 1'b0, "R3 not yet applied");
        expect_at(2, C_IDL, 1'b0, 2'b01, 1'b0, "R3 R2 idle settings");
        send(3'd1);
        step(3);

        // R6 wake from idle
        expect_at(2, C_IDL, 1'b0, 2'b01, 1'b0, "R6 wake latency");
        expect_at(3, C_ACT, 1'b0, 2'b00, 1'b0, "R6 wake idle to active");
        pulse_wake();
        step(4);

        // R4 power-down with held commands (R8), then power-up (R5)
        expect_at(2,  C_PDG, 1'b1, 2'b00, 1'b0, "R4 clocks gated first");
        expect_at(5,  C_PDG, 1'b1, 2'b00, 1'b0, "R4 R8 gate window holds");
        expect_at(6,  C_PDI, 1'b1, 2'b00, 1'b0, "R4 isolation before cut");
        expect_at(7,  C_SLP, 1'b0, 2'b10, 1'b0, "R4 R2 R10 sleep reached");
        expect_at(8,  C_PUL, 1'b1, 2'b10, 1'b0, "R8 held command applied");
        expect_at(12, C_PUL, 1'b1, 2'b10, 1'b0, "R5 waits for power-good");
        expect_at(13, C_PUO, 1'b1, 2'b10, 1'b0, "R5 isolation release");
        expect_at(14, C_IDL, 1'b0, 2'b01, 1'b0, "R8 newest command wins");
        send(3'd2);
        step(1);
        send(3'd3);
        send(3'd1);
        step(2);
        pgood = 1'b0;
        step(4);
        pgood = 1'b1;
        step(6);

        // R6 wake from sleep
        expect_at(2, C_PDG, 1'b1, 2'b01, 1'b0, "R4 from idle");
        expect_at(6, C_PDI, 1'b1, 2'b01, 1'b0, "R4 from idle iso");
        expect_at(7, C_SLP, 1'b0, 2'b10, 1'b0, "R4 sleep from idle");
        send(3'd2);
        step(5);
        pgood = 1'b0;
        step(4);
        expect_at(3, C_PUL, 1'b1, 2'b10, 1'b0, "R6 wake from sleep");
        expect_at(6, C_PUL, 1'b1, 2'b10, 1'b0, "R5 R6 pgood wait");
        expect_at(7, C_PUO, 1'b1, 2'b10, 1'b0, "R5 R6 release");
        expect_at(8, C_ACT, 1'b0, 2'b00, 1'b0, "R6 active after wake");
        pulse_wake();
        step(3);
        pgood = 1'b1;
        step(6);

        // hibernate entry
        expect_at(2, C_PDG, 1'b1, 2'b00, 1'b0, "R4 toward hibernate");
        expect_at(6, C_PDI, 1'b1, 2'b00, 1'b0, "R4 hibernate iso");
        expect_at(7, C_HIB, 1'b0, 2'b11, 1'b0, "R2 hibernate settings");
        send(3'd3);
        step(5);
        pgood = 1'b0;
        step(3);

        // R7 wake ignored in hibernate
        expect_at(3, C_HIB, 1'b0, 2'b11, 1'b0, "R7 wake ignored");
        expect_at(6, C_HIB, 1'b0, 2'b11, 1'b0, "R7 still hibernate");
        pulse_wake();
        step(7);

        // R9 illegal code
        expect_at(1, C_HIB, 1'b0, 2'b11, 1'b1, "R9 error flag set");
        expect_at(3, C_HIB, 1'b0, 2'b11, 1'b1, "R9 illegal ignored");
        send(3'b110);
        step(4);

        // R9 clear
        expect_at(1, C_HIB, 1'b0, 2'b11, 1'b0, "R9 error cleared");
        err_clr = 1'b1;
        step(1);
        err_clr = 1'b0;
        step(2);

        // R3 hibernate to sleep, sleep to hibernate
        expect_at(2, C_SLP, 1'b0, 2'b10, 1'b0, "R3 hibernate to sleep");
        send(3'd2);
        step(3);
        expect_at(2, C_HIB, 1'b0, 2'b11, 1'b0, "R3 sleep to hibernate");
        send(3'd3);
        step(3);

        // R5 hibernate to active
        expect_at(2, C_PUL, 1'b1, 2'b11, 1'b0, "R5 shutdown released");
        expect_at(5, C_PUL, 1'b1, 2'b11, 1'b0, "R5 power-good pending");
        expect_at(6, C_PUO, 1'b1, 2'b11, 1'b0, "R5 iso off after pgood");
        expect_at(7, C_ACT, 1'b0, 2'b00, 1'b0, "R5 active restored");
        send(3'd0);
        step(2);
        pgood = 1'b1;
        step(8);

        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            n_fail++;
            $display("FAIL %s: actual never sampled expected %b", e.tag, e.v);
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule